// File: doc/BRIEF.md
# Pipelined Two-Input ADC Scan Sequencer

This block is an SPI master for a 12-bit serial converter with two analog inputs. The converter's channel choice is pipelined: the input selected in one frame's command applies to the next conversion, not the current one. On each trigger the sequencer issues one or two 16-bit full-duplex frames in SPI mode 0. It extracts the 12-bit results and presents each one as a sample with a one-cycle valid strobe and a channel tag.

Three scan modes are supported: input 0 alone, input 1 alone, and both inputs. Because commands take effect one frame late, the sequencer sends each command one frame ahead. When the scan mode changes it inserts a result-less dummy frame, either to point the converter at input 1 or to return it to its default of input 0. A mode change takes effect only while the sequencer is idle. A trigger that cannot start a scan is dropped and flagged.

The control state machine has five states. ST_IDLE waits for work. ST_PRIME sends a dummy frame that loads the channel a new mode needs. ST_PARK sends a dummy frame for input 0 when scanning is switched off. ST_LEAD sends the first conversion frame of a scan. ST_TAIL sends the second frame of a two-input scan.

The transitions are as follows. "mode change to off" goes from ST_IDLE to ST_PARK. "mode change needing another channel" goes from ST_IDLE to ST_PRIME. "mode change with channel already right" stays in ST_IDLE. "trigger with scan on" goes from ST_IDLE to ST_LEAD. "dummy done" goes from ST_PRIME or ST_PARK to ST_IDLE. "lead done, two-input scan" goes from ST_LEAD to ST_TAIL. "lead done, one-input scan" goes from ST_LEAD to ST_IDLE. "tail done" goes from ST_TAIL to ST_IDLE.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is asserted and right after it, cs_n is 1 and sclk, mosi, sample_valid and overrun are 0.
- R2: Each frame holds cs_n low for exactly 16 rising sclk edges. sclk is low whenever cs_n is high. mosi changes only while sclk is low, and miso is captured on each rising edge. Each sclk half period lasts clk_div+1 clock cycles. cs_n stays high for at least one clock cycle between frames.
- R3: The 16-bit word shifted out MSB first is {control byte, 8'h00}. The control byte is {2'b00, !ext_ref (bit 5), dual_en (bit 4), input-1 select (bit 3), 1'b0, pwr_mode (bits 1:0)}. ext_ref, dual_en, pwr_mode and clk_div are captured when the sequencer leaves idle; changes made during activity do not affect the frames in flight.
- R4: The sample is the low 12 bits of the 16-bit word received MSB first. The upper 4 bits are discarded.
- R5: In input-0 mode (scan_mode=1) each trigger sends one frame commanding input 0 and yields one sample with tag 0.
- R6: In input-1 mode (scan_mode=2) each trigger sends one frame commanding input 1 and yields one sample with tag 1.
- R7: In two-input mode (scan_mode=3) a trigger sends a frame commanding input 1, which yields a tag-0 sample, and then a frame commanding input 0, which yields a tag-1 sample.
- R8: On a change to an enabled mode, one dummy frame is sent first if the converter is not yet pointed at the mode's first input. That input is input 1 for input-1 mode and input 0 otherwise. The dummy frame commands that input. If the converter is already pointed there, no frame is sent.
- R9: Changing scan_mode to 0 (off) from an enabled mode sends one dummy frame commanding input 0.
- R10: A scan_mode change made while frames are in progress does not alter the running scan. It is applied once the sequencer is idle again.
- R11: A trigger that arrives while frames are in progress, or in the cycle an idle mode change is taken, starts nothing and raises overrun for one cycle. A trigger while scanning is off is ignored without overrun.
- R12: sample_valid is a one-cycle pulse that follows the end of a conversion frame. Dummy frames never produce a sample.
- R13: With dual_en low, bits 4 and 3 of every control byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Scan request pulse |
| scan_mode | input | 2 | 0 off, 1 input 0, 2 input 1, 3 both inputs |
| dual_en | input | 1 | Enables two-input operation in the converter |
| ext_ref | input | 1 | An external reference is present (clears the reference-off bit) |
| pwr_mode | input | 2 | Power mode code placed in control bits 1:0 |
| clk_div | input | DIV_W | sclk half period minus one, in clock cycles |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Result data from the converter |
| sample | output | RES_W | Conversion result |
| sample_valid | output | 1 | One-cycle strobe for sample |
| sample_tag | output | 1 | Input that sample belongs to |
| overrun | output | 1 | Dropped-trigger pulse |

## Verification
The assertions assume that the converter behaves as a mode-0 slave, changing miso only after a falling sclk edge or the falling edge of cs_n. They also assume trig is an ordinary synchronous input and that the sequencer starts from reset with the converter at input 0. The bench's converter model keeps to these assumptions. It also tracks its own pipelined channel pointer, which lets each returned sample be checked against the input the converter actually converted. All mode changes, triggers and configuration updates are applied on the falling clock edge. Dropped triggers are provoked by pulsing trig a few cycles after a scan has started.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned CMD_FRAME_W = 16;

    typedef enum logic [1:0] {
        SCAN_OFF  = 2'd0,
        SCAN_IN0  = 2'd1,
        SCAN_IN1  = 2'd2,
        SCAN_BOTH = 2'd3
    } scan_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_PARK,
        ST_LEAD,
        ST_TAIL
    } seq_state_e;

    typedef struct packed {
        logic       ext_ref;
        logic       dual;
        logic [1:0] pm;
    } seq_cfg_t;

    // control byte: bit5 reference off, bit4 dual, bit3 input 1, bits1:0 power
    function automatic logic [7:0] ctrl_byte(seq_cfg_t c, logic in1);
        return {2'b00, ~c.ext_ref, c.dual, in1 & c.dual, 1'b0, c.pm};
    endfunction

endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= div;
        end else if (en) begin
            cnt <= (cnt == '0) ? div : cnt - 1'b1;
        end
    end

    assign tick = en && (cnt == '0);

endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame #(
    parameter int DIV_W   = 8,
    parameter int FRAME_W = 16,
    parameter int RES_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DIV_W-1:0]   div,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               ready,
    output logic               done,
    output logic [RES_W-1:0]   rx_res,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi
);

    localparam int PH_W = $clog2(2 * FRAME_W + 1);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(2 * FRAME_W - 1);

    logic               busy;
    logic [PH_W-1:0]    ph;
    logic [FRAME_W-1:0] tx_sr;
    logic [RES_W-1:0]   rx_sr;
    logic               tick;

    adc_sclk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start && !busy),
        .en    (busy),
        .div   (div),
        .tick  (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            ph    <= '0;
            tx_sr <= '0;
            rx_sr <= '0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    cs_n  <= 1'b0;
                    sclk  <= 1'b0;
                    ph    <= '0;
                    tx_sr <= tx_word;
                end
            end else if (tick) begin
                ph <= ph + 1'b1;
                if (!ph[0]) begin
                    // rising edge: capture; old upper bits fall off the top
                    sclk  <= 1'b1;
                    rx_sr <= {rx_sr[RES_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (ph == LAST_PH) begin
                        busy <= 1'b0;
                        cs_n <= 1'b1;
                        done <= 1'b1;
                    end else begin
                        tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign ready  = !busy;
    assign rx_res = rx_sr;
    assign mosi   = !cs_n && tx_sr[FRAME_W-1];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [1:0]       scan_mode,
    input  logic             dual_en,
    input  logic             ext_ref,
    input  logic [1:0]       pwr_mode,
    input  logic [DIV_W-1:0] clk_div,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic [RES_W-1:0] sample,
    output logic             sample_valid,
    output logic             sample_tag,
    output logic             overrun
);

    localparam int FRAME_W = CMD_FRAME_W;

    seq_state_e       state, nxt;
    scan_mode_e       act_mode, req_mode;
    seq_cfg_t         cfg_q;
    logic [DIV_W-1:0] div_q;
    logic             dev_ptr;

    logic             take_mode;
    logic             in_frame;
    logic             frame_ch;
    logic             eng_ready, eng_done, go;
    logic [RES_W-1:0] rx_res;
    logic [FRAME_W-1:0] tx_word;

    assign req_mode = scan_mode_e'(scan_mode);

    // next-state logic
    always_comb begin
        nxt       = state;
        take_mode = 1'b0;
        in_frame  = 1'b0;
        frame_ch  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_mode != act_mode) begin
                    take_mode = 1'b1;
                    if (req_mode == SCAN_OFF)
                        nxt = ST_PARK;
                    else if (dev_ptr != (req_mode == SCAN_IN1))
                        nxt = ST_PRIME;
                end else if (trig && act_mode != SCAN_OFF) begin
                    nxt = ST_LEAD;
                end
            end
            ST_PRIME: begin
                in_frame = 1'b1;
                frame_ch = (act_mode == SCAN_IN1);
                if (eng_done) nxt = ST_IDLE;
            end
            ST_PARK: begin
                in_frame = 1'b1;
                frame_ch = 1'b0;
                if (eng_done) nxt = ST_IDLE;
            end
            ST_LEAD: begin
                in_frame = 1'b1;
                frame_ch = (act_mode != SCAN_IN0);
                if (eng_done) nxt = (act_mode == SCAN_BOTH) ? ST_TAIL : ST_IDLE;
            end
            ST_TAIL: begin
                in_frame = 1'b1;
                frame_ch = 1'b0;
                if (eng_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered outputs and context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_mode     <= SCAN_OFF;
            cfg_q        <= '0;
            div_q        <= '0;
            dev_ptr      <= 1'b0;
            sample       <= '0;
            sample_valid <= 1'b0;
            sample_tag   <= 1'b0;
            overrun      <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            overrun      <= trig && !(state == ST_IDLE && !take_mode);
            if (take_mode) act_mode <= req_mode;
            if (state == ST_IDLE && nxt != ST_IDLE) begin
                cfg_q <= '{ext_ref: ext_ref, dual: dual_en, pm: pwr_mode};
                div_q <= clk_div;
            end
            if (eng_done && in_frame) dev_ptr <= frame_ch & cfg_q.dual;
            if (eng_done && (state == ST_LEAD || state == ST_TAIL)) begin
                sample_valid <= 1'b1;
                sample       <= rx_res;
                sample_tag   <= (state == ST_TAIL) || (act_mode == SCAN_IN1);
            end
        end
    end

    assign go      = in_frame && eng_ready && !eng_done;
    assign tx_word = {ctrl_byte(cfg_q, frame_ch), 8'h00};

    adc_spi_frame #(
        .DIV_W   (DIV_W),
        .FRAME_W (FRAME_W),
        .RES_W   (RES_W)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go),
        .div     (div_q),
        .tx_word (tx_word),
        .miso    (miso),
        .ready   (eng_ready),
        .done    (eng_done),
        .rx_res  (rx_res),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic trig,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic sample_valid,
    input logic overrun
);

    logic [5:0] n_rise;
    logic       sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_rise <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (cs_n)                n_rise <= '0;
            else if (sclk && !sclk_d) n_rise <= n_rise + 1'b1;
        end
    end

    p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> n_rise == 6'd16);

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_cs_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));

    p_overrun_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(trig));

    p_valid_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    p_valid_after_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (cs_n && $past(cs_n) && !$past(cs_n, 2)));

endmodule

bind adc_scan_seq adc_scan_seq_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig         (trig),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .mosi         (mosi),
    .sample_valid (sample_valid),
    .overrun      (overrun)
);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  scan_mode = 2'd0;
    logic        dual_en = 1'b1;
    logic        ext_ref = 1'b0;
    logic [1:0]  pwr_mode = 2'd3;
    logic [7:0]  clk_div = 8'd0;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;
    logic [11:0] sample;
    logic        sample_valid, sample_tag, overrun;

    always #4 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .scan_mode(scan_mode),
        .dual_en(dual_en), .ext_ref(ext_ref), .pwr_mode(pwr_mode), .clk_div(clk_div),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .sample(sample), .sample_valid(sample_valid), .sample_tag(sample_tag),
        .overrun(overrun)
    );

    int total = 0;
    int bad = 0;

    // converter model with pipelined channel pointer
    logic [15:0] f_cmd [256];
    logic [15:0] f_word[256];
    bit          f_ch  [256];
    int          f_bits[256];
    time         f_dt  [256];
    int          nf = 0;

    bit          m_ptr = 1'b0;
    bit          m_in = 1'b0;
    bit          m_ch;
    logic [15:0] m_word, m_sh, m_rx;
    int          m_bits;
    time         m_t1, m_t2;

    always @(negedge cs_n) begin
        m_in   = 1'b1;
        m_bits = 0;
        m_ch   = m_ptr;
        m_word = {4'hA ^ {3'b000, m_ptr}, 12'(nf * 173 + (m_ptr ? 1111 : 0) + 7)};
        m_sh   = m_word;
        miso   = m_sh[15];
    end

    always @(negedge sclk) if (m_in) begin
        m_sh = {m_sh[14:0], 1'b0};
        miso = m_sh[15];
    end

    always @(posedge sclk) if (m_in) begin
        m_rx = {m_rx[14:0], mosi};
        m_bits++;
        if (m_bits == 1) m_t1 = $time;
        if (m_bits == 2) m_t2 = $time;
    end

    always @(posedge cs_n) if (m_in) begin
        m_in = 1'b0;
        if (nf < 256) begin
            f_cmd[nf]  = m_rx;
            f_word[nf] = m_word;
            f_ch[nf]   = m_ch;
            f_bits[nf] = m_bits;
            f_dt[nf]   = m_t2 - m_t1;
        end
        nf++;
        m_ptr = m_rx[12] & m_rx[11];
    end

    // sample and overrun capture
    logic [11:0] s_val[256];
    bit          s_tag[256];
    int          ns = 0;
    int          n_ovr = 0;

    always @(negedge clk) begin
        if (sample_valid) begin
            if (ns < 256) begin
                s_val[ns] = sample;
                s_tag[ns] = sample_tag;
            end
            ns++;
        end
        if (overrun) n_ovr++;
    end

    bit       cfg_ext, cfg_dual;
    bit [1:0] cfg_pm;
    int       cfg_div;
    int       f0, s0, o0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_frame(input int idx, input bit ch, input string req);
        logic [15:0] exp;
        exp = {2'b00, ~cfg_ext, cfg_dual, ch & cfg_dual, 1'b0, cfg_pm, 8'h00};
        chk(f_cmd[idx] == exp, req, "command word", int'(f_cmd[idx]), int'(exp));
        chk(f_bits[idx] == 16, "R2", "sclk edges per frame", f_bits[idx], 16);
        chk(f_dt[idx] == time'(16 * (cfg_div + 1)), "R2", "sclk period ns",
            int'(f_dt[idx]), 16 * (cfg_div + 1));
    endtask

    task automatic check_sample(input int sidx, input int fidx, input bit tag,
                                input string req);
        chk(s_tag[sidx] == tag, req, "sample tag", int'(s_tag[sidx]), int'(tag));
        chk(f_ch[fidx] == tag, req, "converted input", int'(f_ch[fidx]), int'(tag));
        chk(s_val[sidx] == f_word[fidx][11:0], "R4", "sample value",
            int'(s_val[sidx]), int'(f_word[fidx][11:0]));
    endtask

    task automatic settle;
        repeat (150 * (cfg_div + 1) + 60) @(negedge clk);
    endtask

    task automatic mark;
        f0 = nf; s0 = ns; o0 = n_ovr;
    endtask

    task automatic counts(input int nfr, input int nsm, input string req);
        chk(nf - f0 == nfr, req, "frame count", nf - f0, nfr);
        chk(ns - s0 == nsm, "R12", "sample count", ns - s0, nsm);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) scan_mode = m;
    endtask

    task automatic pulse_trig;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic apply_cfg;
        @(negedge clk);
        dual_en  = cfg_dual;
        ext_ref  = cfg_ext;
        pwr_mode = cfg_pm;
        clk_div  = 8'(cfg_div);
    endtask

    task automatic run_sequence;
        mark; set_mode(2'd1); settle;              // R8: already at input 0
        counts(0, 0, "R8");

        mark; pulse_trig; settle; pulse_trig; settle;
        counts(2, 2, "R5");
        check_frame(f0, 1'b0, "R5"); check_frame(f0 + 1, 1'b0, "R5");
        check_sample(s0, f0, 1'b0, "R5"); check_sample(s0 + 1, f0 + 1, 1'b0, "R5");

        mark; set_mode(2'd2); settle;              // R8 dummy to input 1
        counts(1, 0, "R8");
        check_frame(f0, 1'b1, "R8");

        mark; pulse_trig;
        repeat (3) @(negedge clk);
        pwr_mode = ~cfg_pm;                        // R3: mid-frame change ignored
        settle;
        pwr_mode = cfg_pm;
        counts(1, 1, "R6");
        check_frame(f0, 1'b1, "R3");
        check_sample(s0, f0, 1'b1, "R6");

        mark; set_mode(2'd3); settle;              // R8 dummy back to input 0
        counts(1, 0, "R8");
        check_frame(f0, 1'b0, "R8");

        mark; pulse_trig; settle;
        counts(2, 2, "R7");
        check_frame(f0, 1'b1, "R7"); check_frame(f0 + 1, 1'b0, "R7");
        check_sample(s0, f0, 1'b0, "R7"); check_sample(s0 + 1, f0 + 1, 1'b1, "R7");

        mark; pulse_trig;                          // R11 trigger while busy
        repeat (4) @(negedge clk);
        pulse_trig; settle;
        counts(2, 2, "R11");
        chk(n_ovr - o0 == 1, "R11", "overrun pulses", n_ovr - o0, 1);

        mark; pulse_trig;                          // R10 mode change while busy
        repeat (4) @(negedge clk);
        scan_mode = 2'd1;
        settle;
        counts(2, 2, "R10");
        check_sample(s0, f0, 1'b0, "R10"); check_sample(s0 + 1, f0 + 1, 1'b1, "R10");

        mark; pulse_trig; settle;
        counts(1, 1, "R10");
        check_frame(f0, 1'b0, "R10");
        check_sample(s0, f0, 1'b0, "R10");

        mark; set_mode(2'd0); settle;              // R9 restore frame
        counts(1, 0, "R9");
        check_frame(f0, 1'b0, "R9");

        mark; pulse_trig; settle;                  // R11 trigger while off
        counts(0, 0, "R11");
        chk(n_ovr == o0, "R11", "overrun while off", n_ovr - o0, 0);
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
        chk(mosi == 1'b0, "R1", "mosi in reset", int'(mosi), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sample_valid == 1'b0, "R1", "valid after reset", int'(sample_valid), 0);
        chk(overrun == 1'b0, "R1", "overrun after reset", int'(overrun), 0);
        chk(cs_n == 1'b1, "R1", "cs_n after reset", int'(cs_n), 1);

        for (int d = 0; d < 3; d += 2) begin
            for (int p = 0; p < 4; p++) begin
                cfg_div  = d;
                cfg_pm   = 2'(p);
                cfg_ext  = p[0] ^ d[1];
                cfg_dual = 1'b1;
                apply_cfg;
                run_sequence;
            end
        end

        // R13: dual mode disabled masks bits 4 and 3
        cfg_div = 1; cfg_pm = 2'd3; cfg_ext = 1'b0; cfg_dual = 1'b0;
        apply_cfg;
        mark; set_mode(2'd1); settle;
        pulse_trig; settle;
        counts(1, 1, "R13");
        check_frame(f0, 1'b0, "R13");
        mark; set_mode(2'd2); settle;
        counts(1, 0, "R13");
        check_frame(f0, 1'b1, "R13");
        mark; set_mode(2'd0); settle;
        counts(1, 0, "R13");
        check_frame(f0, 1'b0, "R13");

        finish_run;
    end

endmodule